// File: doc/BRIEF.md
# SATA Host Port Control Register Block

This block is a register-level model of one SATA host port together with the host-wide control bits. Software reaches it through a simple 32-bit register bus with a word address, a write strobe and a combinational read path. The block holds a port command register with two handshakes. The first is receive-enable against receive-running. The second is start against command-list-running. Each running bit trails its enable by a programmable number of cycles.

Start is honoured only while the device is ready. Ready means the task-file status shows neither busy nor data-request, and the link-detect field reports an established device. A port interrupt status register and a port error register are both write-one-to-clear and are fed by event pulses from the rest of the port. An enable mask with fixed reserved positions decides which status bits raise the port's bit in a host-wide interrupt summary. That summary drives the interrupt line when the host interrupt enable is set.

Word offsets: 0 host control, 1 interrupt summary, 2 port command, 3 port interrupt status, 4 port interrupt enable, 5 port error. Any other offset reads zero and ignores writes.

Top module: `sata_port_regs`

## Requirements
- R1: After reset every register reads zero, and both `irq` and `err_flag` are low.
- R2: Host control bit 0 (host mode enable) and bit 1 (host interrupt enable) read back as written. All other host control bits read zero.
- R3: Receive-enable is port command bit 4. Receive-running is bit 14. It takes the value of bit 4 exactly RUN_DLY cycles after the write that changed bit 4.
- R4: Start is port command bit 0. A write of 1 to it takes effect only when `tf_busy` is 0, `tf_drq` is 0 and `link_det` equals 4'h3. Otherwise the start bit and command-list-running stay 0.
- R5: Command-list-running is port command bit 15. It follows the start bit exactly RUN_DLY cycles after a change. Clearing start and receive-enable clears both running bits within RUN_DLY cycles.
- R6: A 1 on `evt_pulse[i]` sets port interrupt status bit i at the next edge. Writing 1 to a status bit clears it, and a set in the same cycle wins over the clear.
- R7: The port error register behaves the same way with `err_pulse`: it sets on a pulse, clears on a written 1, and a set wins over a clear in the same cycle.
- R8: The interrupt enable register keeps only bits 31:26, 24:22 and 7:0 (mask 32'hFDC0_00FF). Writing all ones reads back 32'hFDC0_00FF.
- R9: `err_flag` is high exactly when any of port interrupt status bits 31:23 is set.
- R10: Summary bit PORT_IDX (bit 2 by default) sets one cycle after any status bit is both set and enabled. It then holds until a 1 is written to it while nothing is pending.
- R11: `irq` is high when the summary bit is set and the host interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tf_busy | input | 1 | Task-file busy status |
| tf_drq | input | 1 | Task-file data-request status |
| link_det | input | 4 | Link-detect field |
| evt_pulse | input | DATA_W | Per-bit interrupt status set pulses |
| err_pulse | input | DATA_W | Per-bit error set pulses |
| irq | output | 1 | Port interrupt to the host |
| err_flag | output | 1 | Any error-group status bit set |

## Verification
The assertions assume the inputs are held at zero during reset, so nothing is pending when reset is released. They also assume each write strobe lasts one cycle with address and data stable. The bench drives every input on the falling edge, keeps the pulses idle through reset, and raises each write strobe for exactly one cycle. The start-gating checks hold `tf_busy`, `tf_drq` and `link_det` steady around each write, so the decision depends only on the values present at that write's edge.

// File: rtl/sata_port_pkg.sv
package sata_port_pkg;

    // register word offsets
    localparam int OFF_GCTL = 0;
    localparam int OFF_GSUM = 1;
    localparam int OFF_PCMD = 2;
    localparam int OFF_PIS  = 3;
    localparam int OFF_PIE  = 4;
    localparam int OFF_PERR = 5;

    // host control bit positions
    localparam int GC_HOST_EN = 0;
    localparam int GC_IRQ_EN  = 1;

    // port command bit positions
    localparam int PC_START    = 0;
    localparam int PC_RX_EN    = 4;
    localparam int PC_RX_RUN   = 14;
    localparam int PC_LIST_RUN = 15;

    typedef struct packed {
        logic start;
        logic rx_en;
    } cmd_ctl_t;

    typedef struct packed {
        logic list_run;
        logic rx_run;
    } cmd_run_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GCTL,
        SEL_GSUM,
        SEL_PCMD,
        SEL_PIS,
        SEL_PIE,
        SEL_PERR
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input int off);
        case (off)
            OFF_GCTL: return SEL_GCTL;
            OFF_GSUM: return SEL_GSUM;
            OFF_PCMD: return SEL_PCMD;
            OFF_PIS:  return SEL_PIS;
            OFF_PIE:  return SEL_PIE;
            OFF_PERR: return SEL_PERR;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spr_w1c_reg.sv
module spr_w1c_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] q;
    logic             past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            past_ok <= 1'b0;
        end else begin
            q       <= (q & ~clr_i) | set_i;
            past_ok <= 1'b1;
        end
    end

    assign q_o = q;

    // R6 and R7: a written one without a concurrent set leaves the bit clear
    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((q_o & $past(clr_i & ~set_i)) == '0));

    // R6 and R7: a set pulse always lands, even against a clear
    p_w1c_set_r7: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (($past(set_i) & ~q_o) == '0));

endmodule

// File: rtl/spr_run_follow.sv
module spr_run_follow #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic run_o
);

    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (en_i != run_q) begin
            if (cnt_q == CW'(DLY - 1)) begin
                run_q <= en_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign run_o = run_q;

    // checker state: cycles the running bit has disagreed with its enable
    logic [CW:0] mis_q;
    logic        past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            mis_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            mis_q   <= (en_i != run_o) ? mis_q + 1'b1 : '0;
            past_ok <= 1'b1;
        end
    end

    // R3: the running bit only ever moves toward its enable
    p_follow_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(run_o)) |-> (run_o == $past(en_i)));

    // R5: the running bit never lags its enable by more than DLY cycles
    p_lag_bound_r5: assert property (@(posedge clk) disable iff (rst)
        mis_q <= (CW + 1)'(DLY));

endmodule

// File: rtl/spr_cmd_ctrl.sv
module spr_cmd_ctrl
    import sata_port_pkg::*;
#(
    parameter int RUN_DLY = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  cmd_ctl_t wr_ctl_i,
    input  logic     start_ok_i,
    output cmd_ctl_t ctl_o,
    output cmd_run_t run_o
);

    localparam int NUM_HS = $bits(cmd_ctl_t);

    cmd_ctl_t          ctl_q;
    logic [NUM_HS-1:0] en_vec;
    logic [NUM_HS-1:0] run_vec;
    logic              past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (wr_i) begin
                ctl_q.rx_en <= wr_ctl_i.rx_en;
                // a new start is taken only while the device is ready
                ctl_q.start <= wr_ctl_i.start & (ctl_q.start | start_ok_i);
            end
        end
    end

    assign en_vec = ctl_q;

    for (genvar g = 0; g < NUM_HS; g++) begin : g_hs
        spr_run_follow #(
            .DLY (RUN_DLY)
        ) u_follow (
            .clk   (clk),
            .rst   (rst),
            .en_i  (en_vec[g]),
            .run_o (run_vec[g])
        );
    end

    assign ctl_o = ctl_q;
    assign run_o = run_vec;

    // R4: start only rises across a write made while the device was ready
    p_start_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(ctl_o.start)) |-> ($past(start_ok_i) && $past(wr_i)));

endmodule

// File: rtl/sata_port_regs.sv
module sata_port_regs
    import sata_port_pkg::*;
#(
    parameter int          ADDR_W     = 3,
    parameter int          DATA_W     = 32,
    parameter int          RUN_DLY    = 4,
    parameter int          PORT_IDX   = 2,
    parameter int          ERR_LSB    = 23,
    parameter logic [31:0] IE_WR_MASK = 32'hFDC0_00FF,
    parameter logic [3:0]  LINK_READY = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tf_busy,
    input  logic              tf_drq,
    input  logic [3:0]        link_det,
    input  logic [DATA_W-1:0] evt_pulse,
    input  logic [DATA_W-1:0] err_pulse,
    output logic              irq,
    output logic              err_flag
);

    localparam int          GC_W    = 2;
    localparam logic [DATA_W-1:0] PIE_MASK = DATA_W'(IE_WR_MASK);

    reg_sel_e          sel;
    logic              wr_gctl, wr_gsum, wr_pcmd, wr_pis, wr_pie, wr_perr;
    logic [GC_W-1:0]   gctl_q;
    logic [DATA_W-1:0] pie_q;
    logic [DATA_W-1:0] pis_q;
    logic [DATA_W-1:0] perr_q;
    logic              sum_q;
    logic              pending;
    logic              clr_sum;
    logic              start_ok;
    logic              past_ok;
    cmd_ctl_t          wr_ctl;
    cmd_ctl_t          ctl;
    cmd_run_t          run;

    // address decode
    always_comb begin
        sel     = decode_sel(int'(bus_addr));
        wr_gctl = bus_wr && (sel == SEL_GCTL);
        wr_gsum = bus_wr && (sel == SEL_GSUM);
        wr_pcmd = bus_wr && (sel == SEL_PCMD);
        wr_pis  = bus_wr && (sel == SEL_PIS);
        wr_pie  = bus_wr && (sel == SEL_PIE);
        wr_perr = bus_wr && (sel == SEL_PERR);
    end

    // host control and interrupt enable
    always_ff @(posedge clk) begin
        if (rst) begin
            gctl_q  <= '0;
            pie_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (wr_gctl) begin
                gctl_q[GC_HOST_EN] <= bus_wdata[GC_HOST_EN];
                gctl_q[GC_IRQ_EN]  <= bus_wdata[GC_IRQ_EN];
            end
            if (wr_pie) begin
                pie_q <= bus_wdata & PIE_MASK;
            end
        end
    end

    // port command handshakes
    assign start_ok     = !tf_busy && !tf_drq && (link_det == LINK_READY);
    assign wr_ctl.start = bus_wdata[PC_START];
    assign wr_ctl.rx_en = bus_wdata[PC_RX_EN];

    spr_cmd_ctrl #(
        .RUN_DLY (RUN_DLY)
    ) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_pcmd),
        .wr_ctl_i   (wr_ctl),
        .start_ok_i (start_ok),
        .ctl_o      (ctl),
        .run_o      (run)
    );

    // write-one-to-clear status and error
    spr_w1c_reg #(
        .WIDTH (DATA_W)
    ) u_pis (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_pulse),
        .clr_i (wr_pis ? bus_wdata : '0),
        .q_o   (pis_q)
    );

    spr_w1c_reg #(
        .WIDTH (DATA_W)
    ) u_perr (
        .clk   (clk),
        .rst   (rst),
        .set_i (err_pulse),
        .clr_i (wr_perr ? bus_wdata : '0),
        .q_o   (perr_q)
    );

    // host-wide summary bit for this port, held until written clear
    assign pending = |(pis_q & pie_q);
    assign clr_sum = wr_gsum && bus_wdata[PORT_IDX];

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= 1'b0;
        end else begin
            sum_q <= (sum_q && !clr_sum) || pending;
        end
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_GCTL: bus_rdata[GC_W-1:0] = gctl_q;
            SEL_GSUM: bus_rdata[PORT_IDX] = sum_q;
            SEL_PCMD: begin
                bus_rdata[PC_START]    = ctl.start;
                bus_rdata[PC_RX_EN]    = ctl.rx_en;
                bus_rdata[PC_RX_RUN]   = run.rx_run;
                bus_rdata[PC_LIST_RUN] = run.list_run;
            end
            SEL_PIS:  bus_rdata = pis_q;
            SEL_PIE:  bus_rdata = pie_q;
            SEL_PERR: bus_rdata = perr_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq      = sum_q && gctl_q[GC_IRQ_EN];
    assign err_flag = |pis_q[DATA_W-1:ERR_LSB];

    // R10: an enabled pending status reaches the summary one cycle later
    p_sum_set_r10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(pending)) |-> sum_q);

    // R10: the summary holds until a one is written to it
    p_sum_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sum_q) && !$past(clr_sum)) |-> sum_q);

    // R11: the interrupt line never rises without a summary bit to back it
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(irq)) |-> ($past(pending) || $past(sum_q)));

endmodule

// File: tb/test_sata_port_regs.sv
`timescale 1ns/1ps
module test_sata_port_regs;

    localparam int DLY  = 4;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        tf_busy, tf_drq;
    logic [3:0]  link_det;
    logic [31:0] evt_pulse, err_pulse;
    logic        irq, err_flag;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sata_port_regs i_sata_port_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tf_busy   (tf_busy),
        .tf_drq    (tf_drq),
        .link_det  (link_det),
        .evt_pulse (evt_pulse),
        .err_pulse (err_pulse),
        .irq       (irq),
        .err_flag  (err_flag)
    );

    typedef struct packed {
        logic [2:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    // write then read back; R2 host control, R8 enable mask, R6/R7 clear of empty regs
    localparam vec_t VEC [NVEC] = '{
        '{a: 3'd0, w: 32'hFFFF_FFFF, e: 32'h0000_0003},
        '{a: 3'd0, w: 32'h0000_0000, e: 32'h0000_0000},
        '{a: 3'd0, w: 32'h0000_0002, e: 32'h0000_0002},
        '{a: 3'd4, w: 32'hFFFF_FFFF, e: 32'hFDC0_00FF},
        '{a: 3'd4, w: 32'h0000_FF00, e: 32'h0000_0000},
        '{a: 3'd4, w: 32'h0000_0001, e: 32'h0000_0001},
        '{a: 3'd3, w: 32'hFFFF_FFFF, e: 32'h0000_0000},
        '{a: 3'd5, w: 32'hFFFF_FFFF, e: 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ev(input logic [2:0] a, input logic [31:0] d,
                         input logic [31:0] ev, input logic [31:0] er);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        evt_pulse = ev;
        err_pulse = er;
        @(negedge clk);
        bus_wr    = 1'b0;
        evt_pulse = '0;
        err_pulse = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_ev(a, d, '0, '0);
    endtask

    task automatic pulse(input logic [31:0] ev, input logic [31:0] er);
        @(negedge clk);
        evt_pulse = ev;
        err_pulse = er;
        @(negedge clk);
        evt_pulse = '0;
        err_pulse = '0;
    endtask

    // reads at the current time, no clock edge consumed
    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        tf_busy = 1'b0; tf_drq = 1'b0; link_det = 4'h0;
        evt_pulse = '0; err_pulse = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), d);
            chk("R1 reset register", d, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
        chk("R1 reset err_flag", {31'b0, err_flag}, 32'h0);

        // table walk: R2, R8, R6, R7
        for (int v = 0; v < NVEC; v++) begin
            wr(VEC[v].a, VEC[v].w);
            rd(VEC[v].a, d);
            chk("R2 R8 R6 R7 table readback", d, VEC[v].e);
        end

        // R3 receive handshake
        wr(3'd2, 32'h0000_0010);
        rd(3'd2, d); chk("R3 rx_en set, rx_run not yet", d, 32'h0000_0010);
        repeat (DLY - 1) @(negedge clk);
        rd(3'd2, d); chk("R3 rx_run one cycle early", d, 32'h0000_0010);
        @(negedge clk);
        rd(3'd2, d); chk("R3 rx_run after delay", d, 32'h0000_4010);

        // R4 start gating
        link_det = 4'h3; tf_busy = 1'b1;
        wr(3'd2, 32'h0000_0011);
        rd(3'd2, d); chk("R4 start ignored while busy", d, 32'h0000_4010);
        repeat (DLY + 1) @(negedge clk);
        rd(3'd2, d); chk("R4 no list_run while busy", d, 32'h0000_4010);
        tf_busy = 1'b0; tf_drq = 1'b1;
        wr(3'd2, 32'h0000_0011);
        rd(3'd2, d); chk("R4 start ignored on drq", d, 32'h0000_4010);
        tf_drq = 1'b0; link_det = 4'h1;
        wr(3'd2, 32'h0000_0011);
        repeat (DLY + 1) @(negedge clk);
        rd(3'd2, d); chk("R4 start ignored without link", d, 32'h0000_4010);
        link_det = 4'h3;
        wr(3'd2, 32'h0000_0011);
        rd(3'd2, d); chk("R4 start accepted when ready", d, 32'h0000_4011);

        // R5 list_run follows start
        repeat (DLY - 1) @(negedge clk);
        rd(3'd2, d); chk("R5 list_run one cycle early", d, 32'h0000_4011);
        @(negedge clk);
        rd(3'd2, d); chk("R5 list_run after delay", d, 32'h0000_C011);

        // R5 stopping drops both running bits
        tf_busy = 1'b1;
        wr(3'd2, 32'h0000_0000);
        repeat (DLY - 1) @(negedge clk);
        rd(3'd2, d); chk("R5 running bits still draining", d, 32'h0000_C000);
        @(negedge clk);
        rd(3'd2, d); chk("R5 port idle within delay", d, 32'h0000_0000);
        tf_busy = 1'b0;

        // R6 and R9 status set and clear
        pulse(32'h8000_0002, '0);
        rd(3'd3, d); chk("R6 status set by pulse", d, 32'h8000_0002);
        chk("R9 err_flag on bit 31", {31'b0, err_flag}, 32'h1);
        wr(3'd3, 32'h8000_0000);
        rd(3'd3, d); chk("R6 write one clears bit", d, 32'h0000_0002);
        chk("R9 err_flag drops", {31'b0, err_flag}, 32'h0);
        pulse(32'h0080_0000, '0);
        chk("R9 err_flag on bit 23", {31'b0, err_flag}, 32'h1);
        wr(3'd3, 32'h0080_0000);
        pulse(32'h0040_0000, '0);
        chk("R9 bit 22 is no error", {31'b0, err_flag}, 32'h0);
        wr(3'd3, 32'h0040_0000);
        wr_ev(3'd3, 32'h0000_0002, 32'h0000_0002, '0);
        rd(3'd3, d); chk("R6 set wins over clear", d, 32'h0000_0002);
        wr(3'd3, 32'h0000_0002);
        rd(3'd3, d); chk("R6 cleared", d, 32'h0);
        rd(3'd1, d); chk("R10 disabled bits raise no summary", d, 32'h0);

        // R7 error register
        pulse('0, 32'h0000_0104);
        rd(3'd5, d); chk("R7 error set by pulse", d, 32'h0000_0104);
        wr_ev(3'd5, 32'h0000_0104, '0, 32'h0000_0004);
        rd(3'd5, d); chk("R7 clear with set winning", d, 32'h0000_0004);
        wr(3'd5, 32'h0000_0004);
        rd(3'd5, d); chk("R7 error cleared", d, 32'h0);

        // R10 and R11 summary and interrupt (PIE=1, host irq enable set)
        @(negedge clk);
        evt_pulse = 32'h1;
        @(negedge clk);
        evt_pulse = '0;
        rd(3'd1, d); chk("R10 summary one cycle behind status", d, 32'h0);
        @(negedge clk);
        rd(3'd1, d); chk("R10 summary set", d, 32'h0000_0004);
        chk("R11 irq raised", {31'b0, irq}, 32'h1);
        wr(3'd1, 32'h0000_0004);
        rd(3'd1, d); chk("R10 summary stays while pending", d, 32'h0000_0004);
        wr(3'd3, 32'h0000_0001);
        @(negedge clk);
        rd(3'd1, d); chk("R10 summary held after status clear", d, 32'h0000_0004);
        wr(3'd1, 32'h0000_0004);
        rd(3'd1, d); chk("R10 summary cleared", d, 32'h0);
        chk("R11 irq dropped", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h0000_0001);
        pulse(32'h1, '0);
        @(negedge clk);
        rd(3'd1, d); chk("R10 summary set again", d, 32'h0000_0004);
        chk("R11 irq masked by host enable", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h0000_0003);
        chk("R11 irq once host enable set", {31'b0, irq}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule